// File: doc/BRIEF.md
# Steppable Timing Pulse Sequencer

This block steps a processor through the twelve timing pulses that make up one memory cycle. It also covers power-up and front-panel debugging. A single 4-bit state register holds all of it: a standby state, a power-on state, the twelve timing-pulse states, and two single-step states. One of the single-step states waits for the step button to be let go. The other waits for the button to be pressed again.

Timing pulses advance on a fast strobe from the clock divider. A slower divider strobe, together with the power-on-reset switch, brings the machine out of standby. At the end of each memory cycle, three switches decide whether the machine runs straight on into the next cycle or parks itself for single stepping: run/step, instruction/sub-sequence and select-next-instruction. On that same transition, an optional breakpoint compares the current instruction address with a preset address. On a hit, the block raises a one-cycle flag that makes the clock source drop into manual mode.

The outputs are the encoded state, a one-hot timing-pulse vector for the control-pulse decoder, and the manual-clock flag. All outputs are registered.

Top module: `tp_sequencer`

## Requirements
- R1: `state_o` uses a fixed encoding. Standby is 0. Timing pulse n (n = 1..12) is n. Power-on is 13. Release-wait is 14. Step-wait is 15.
- R2: While `rst` is high and in the cycle after it, the state is standby (0), `tp_o` is all zeros and `force_manual_o` is low.
- R3: Standby goes to power-on only in a cycle where `por_sw_i` and `slow_stb_i` are both high. Either one alone leaves the machine in standby.
- R4: In timing pulses 1 to 11, each cycle with `fast_stb_i` high moves the state to the next pulse. Without the strobe the state holds. This gives twelve pulses per memory cycle.
- R5: In timing pulse 12, a fast strobe moves the state to pulse 1 when `run_sw_i`=1, `inst_sw_i`=1 and `sni_sw_i`=0. With any other switch setting it moves to release-wait (14).
- R6: Power-on moves to timing pulse 1 on a fast strobe while `por_sw_i` is low. While the switch is held it stays in power-on.
- R7: Release-wait moves to step-wait once the step switch, after its two-flop synchroniser, reads low.
- R8: Step-wait moves to timing pulse 1 on the synchronised rising edge of `step_sw_i`. A press produces exactly one such move. Holding the switch produces no further move, because the edge is detected as a change from low to high.
- R9: When the state is timing pulse n, bit n-1 of `tp_o` is set and no other bit is set. In every other state `tp_o` is all zeros. `tp_o` changes in the same cycle as `state_o`.
- R10: `force_manual_o` is high for exactly one cycle, the cycle in which the state has just left pulse 12. This happens only when, in the cycle of that transition, `bp_en_i` was high and `cur_addr_i` equalled `bp_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_stb_i | input | 1 | Fast divider strobe that advances timing pulses |
| slow_stb_i | input | 1 | Slow divider strobe for leaving standby |
| por_sw_i | input | 1 | Power-on-reset switch |
| run_sw_i | input | 1 | 1 = run freely, 0 = step |
| inst_sw_i | input | 1 | 1 = step by instruction, 0 = by sub-sequence |
| step_sw_i | input | 1 | Momentary step button, asynchronous |
| sni_sw_i | input | 1 | Select-next-instruction, active high |
| bp_en_i | input | 1 | Breakpoint enable |
| bp_addr_i | input | ADDR_W | Breakpoint address |
| cur_addr_i | input | ADDR_W | Address of the current instruction |
| state_o | output | 4 | Encoded sequencer state (R1) |
| tp_o | output | 12 | One-hot timing pulses, bit n-1 = pulse n |
| force_manual_o | output | 1 | One-cycle request to switch the clock to manual |

## Verification
The bench runs a cycle-accurate reference model alongside the design. It starts with directed sequences:
- standby with only one of its two exit conditions present, then with both;
- power-on with the reset switch still held;
- a full twelve-pulse loop with a matching breakpoint;
- a stop at the end of a cycle followed by a release and a press.

These separate the strobe and switch qualifiers that each transition depends on. After that, seeded random strobes, switch settings and step presses mix every state with every input. This exposes off-by-one errors in pulse counting, a wrong switch polarity at pulse 12, a press that counts more than once, and a breakpoint flag raised on an address mismatch or outside the exit from pulse 12.

// File: rtl/tp_seq_pkg.sv
package tp_seq_pkg;

  localparam int TP_COUNT = 12;
  localparam int STATE_W  = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_STBY  = 4'd0,
    ST_TP1   = 4'd1,
    ST_TP2   = 4'd2,
    ST_TP3   = 4'd3,
    ST_TP4   = 4'd4,
    ST_TP5   = 4'd5,
    ST_TP6   = 4'd6,
    ST_TP7   = 4'd7,
    ST_TP8   = 4'd8,
    ST_TP9   = 4'd9,
    ST_TP10  = 4'd10,
    ST_TP11  = 4'd11,
    ST_TP12  = 4'd12,
    ST_PWRON = 4'd13,
    ST_SRLSE = 4'd14,
    ST_WAIT  = 4'd15
  } seq_state_e;

endpackage

// File: rtl/tp_step_sync.sv
module tp_step_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level_o,
  output logic press_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // shift register synchroniser plus one delayed copy for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign press_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tp_next_state.sv
module tp_next_state
  import tp_seq_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       fast_stb_i,
  input  logic       slow_stb_i,
  input  logic       por_sw_i,
  input  logic       run_sw_i,
  input  logic       inst_sw_i,
  input  logic       sni_sw_i,
  input  logic       step_level_i,
  input  logic       step_press_i,
  output seq_state_e next_o,
  output logic       leave_tp12_o
);
  logic keep_running;

  assign keep_running = run_sw_i & inst_sw_i & ~sni_sw_i;
  assign leave_tp12_o = (state_i == ST_TP12) & fast_stb_i;

  always_comb begin
    next_o = state_i;
    case (state_i)
      ST_STBY:  if (por_sw_i && slow_stb_i) next_o = ST_PWRON;
      ST_PWRON: if (!por_sw_i && fast_stb_i) next_o = ST_TP1;
      ST_TP12:  if (fast_stb_i) next_o = keep_running ? ST_TP1 : ST_SRLSE;
      ST_SRLSE: if (!step_level_i) next_o = ST_WAIT;
      ST_WAIT:  if (step_press_i) next_o = ST_TP1;
      default:  if (fast_stb_i) next_o = seq_state_e'(state_i + 4'd1);
    endcase
  end
endmodule

// File: rtl/tp_bkpt_cmp.sv
module tp_bkpt_cmp #(
  parameter int ADDR_W = 12
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] bp_addr_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output logic              hit_o
);
  assign hit_o = en_i & (bp_addr_i == cur_addr_i);
endmodule

// File: rtl/tp_sequencer.sv
module tp_sequencer
  import tp_seq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fast_stb_i,
  input  logic                slow_stb_i,
  input  logic                por_sw_i,
  input  logic                run_sw_i,
  input  logic                inst_sw_i,
  input  logic                step_sw_i,
  input  logic                sni_sw_i,
  input  logic                bp_en_i,
  input  logic [ADDR_W-1:0]   bp_addr_i,
  input  logic [ADDR_W-1:0]   cur_addr_i,
  output logic [STATE_W-1:0]  state_o,
  output logic [TP_COUNT-1:0] tp_o,
  output logic                force_manual_o
);
  seq_state_e          state_q;
  seq_state_e          state_d;
  logic                step_level;
  logic                step_press;
  logic                leave_tp12;
  logic                bp_hit;
  logic [TP_COUNT-1:0] tp_d;

  tp_step_sync #(.STAGES(SYNC_STAGES)) u_step_sync (
    .clk     (clk),
    .rst     (rst),
    .din     (step_sw_i),
    .level_o (step_level),
    .press_o (step_press)
  );

  tp_next_state u_next (
    .state_i      (state_q),
    .fast_stb_i   (fast_stb_i),
    .slow_stb_i   (slow_stb_i),
    .por_sw_i     (por_sw_i),
    .run_sw_i     (run_sw_i),
    .inst_sw_i    (inst_sw_i),
    .sni_sw_i     (sni_sw_i),
    .step_level_i (step_level),
    .step_press_i (step_press),
    .next_o       (state_d),
    .leave_tp12_o (leave_tp12)
  );

  tp_bkpt_cmp #(.ADDR_W(ADDR_W)) u_bkpt (
    .en_i       (bp_en_i),
    .bp_addr_i  (bp_addr_i),
    .cur_addr_i (cur_addr_i),
    .hit_o      (bp_hit)
  );

  // one-hot pulse decode from the next state, so it registers alongside it
  generate
    for (genvar gi = 0; gi < TP_COUNT; gi++) begin : g_tp
      assign tp_d[gi] = (state_d == seq_state_e'(4'(gi + 1)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_STBY;
      tp_o           <= '0;
      force_manual_o <= 1'b0;
    end else begin
      state_q        <= state_d;
      tp_o           <= tp_d;
      force_manual_o <= leave_tp12 & bp_hit;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/tp_sequencer_chk.sv
module tp_sequencer_chk (
  input logic        clk,
  input logic        rst,
  input logic        fast_stb_i,
  input logic        slow_stb_i,
  input logic        por_sw_i,
  input logic        run_sw_i,
  input logic        inst_sw_i,
  input logic        sni_sw_i,
  input logic [3:0]  state_o,
  input logic [11:0] tp_o,
  input logic        force_manual_o
);
  logic in_tp;
  assign in_tp = (state_o >= 4'd1) && (state_o <= 4'd12);

  assert_stby_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd0 && !(por_sw_i && slow_stb_i)) |=> state_o == 4'd0);

  assert_stby_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd0 && por_sw_i && slow_stb_i) |=> state_o == 4'd13);

  assert_tp_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (state_o >= 4'd1 && state_o <= 4'd11 && fast_stb_i) |=> state_o == $past(state_o) + 4'd1);

  assert_tp_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (in_tp && !fast_stb_i) |=> $stable(state_o));

  assert_tp12_loop_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd12 && fast_stb_i && run_sw_i && inst_sw_i && !sni_sw_i) |=> state_o == 4'd1);

  assert_tp12_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd12 && fast_stb_i && !(run_sw_i && inst_sw_i && !sni_sw_i)) |=> state_o == 4'd14);

  assert_pwron_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd13 && fast_stb_i && !por_sw_i) |=> state_o == 4'd1);

  assert_tp_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tp_o) && (in_tp == ($countones(tp_o) == 1)));

  assert_force_source_R10: assert property (@(posedge clk) disable iff (rst)
    force_manual_o |-> ($past(state_o) == 4'd12 && state_o != 4'd12));
endmodule

bind tp_sequencer tp_sequencer_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .fast_stb_i     (fast_stb_i),
  .slow_stb_i     (slow_stb_i),
  .por_sw_i       (por_sw_i),
  .run_sw_i       (run_sw_i),
  .inst_sw_i      (inst_sw_i),
  .sni_sw_i       (sni_sw_i),
  .state_o        (state_o),
  .tp_o           (tp_o),
  .force_manual_o (force_manual_o)
);

// File: tb/tp_sequencer_bench.sv
module tp_sequencer_bench;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fast = 0, slow = 0, por = 0, run = 0, inst = 0, step = 0, sni = 0, bpen = 0;
  logic [AW-1:0] bpa = '0, cur = '0;
  logic [3:0]  st;
  logic [11:0] tp;
  logic        fm;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  logic [3:0] m_st;
  logic       m_fm;
  logic       s1, s2, sp;

  tp_sequencer #(.ADDR_W(AW)) u_tp_sequencer (
    .clk(clk), .rst(rst), .fast_stb_i(fast), .slow_stb_i(slow), .por_sw_i(por),
    .run_sw_i(run), .inst_sw_i(inst), .step_sw_i(step), .sni_sw_i(sni),
    .bp_en_i(bpen), .bp_addr_i(bpa), .cur_addr_i(cur),
    .state_o(st), .tp_o(tp), .force_manual_o(fm)
  );

  always #5 clk = ~clk;

  function automatic logic [3:0] f_next(logic [3:0] s, logic lvl, logic press);
    case (s)
      4'd0:  return (por && slow) ? 4'd13 : 4'd0;
      4'd13: return (!por && fast) ? 4'd1 : 4'd13;
      4'd12: return fast ? ((run && inst && !sni) ? 4'd1 : 4'd14) : 4'd12;
      4'd14: return !lvl ? 4'd15 : 4'd14;
      4'd15: return press ? 4'd1 : 4'd15;
      default: return fast ? s + 4'd1 : s;
    endcase
  endfunction

  function automatic logic [11:0] f_tp(logic [3:0] s);
    if (s >= 4'd1 && s <= 4'd12) return 12'd1 << (s - 4'd1);
    return 12'd0;
  endfunction

  function automatic string f_tag(logic [3:0] s);
    case (s)
      4'd0:  return "R3";
      4'd13: return "R6";
      4'd12: return "R5";
      4'd14: return "R7";
      4'd15: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // inputs are stable now (driven at negedge); advance one clock and compare
  task automatic cycle();
    logic [3:0] nst;
    logic       nfm;
    string      tag;
    tag = f_tag(m_st);
    if (rst) begin
      nst = 4'd0; nfm = 1'b0;
    end else begin
      nst = f_next(m_st, s2, s2 & ~sp);
      nfm = (m_st == 4'd12) && fast && bpen && (cur == bpa);
    end
    @(posedge clk);
    if (rst) begin s1 = 0; s2 = 0; sp = 0; end
    else begin sp = s2; s2 = s1; s1 = step; end
    m_st = nst; m_fm = nfm;
    @(negedge clk);
    check(tag, {28'd0, st}, {28'd0, m_st});
    check("R9", {20'd0, tp}, {20'd0, f_tp(m_st)});
    check("R10", {31'd0, fm}, {31'd0, m_fm});
  endtask

  task automatic do_reset();
    rst = 1; step = 0;
    repeat (3) cycle();
    rst = 0;
    check("R2 state", {28'd0, st}, 32'd0);
    check("R2 tp", {20'd0, tp}, 32'd0);
    check("R2 force", {31'd0, fm}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_st = 0; m_fm = 0; s1 = 0; s2 = 0; sp = 0;
    @(negedge clk);
    do_reset();
    cycle();
    check("R2 after", {28'd0, st}, 32'd0);

    // R3: each exit condition alone keeps standby
    por = 1; slow = 0; fast = 1;
    repeat (4) cycle();
    check("R3 por only", {28'd0, st}, 32'd0);
    por = 0; slow = 1;
    repeat (3) cycle();
    check("R3 slow only", {28'd0, st}, 32'd0);
    por = 1; slow = 1;
    cycle();
    slow = 0;
    check("R1 power-on code", {28'd0, st}, 32'd13);

    // R6: held switch keeps power-on
    fast = 1;
    repeat (3) cycle();
    check("R6 held", {28'd0, st}, 32'd13);
    por = 0; fast = 0;
    cycle();
    check("R6 no strobe", {28'd0, st}, 32'd13);
    fast = 1;
    cycle();
    check("R6 exit", {28'd0, st}, 32'd1);

    // R4/R5/R10: full free-running loop with matching breakpoint
    run = 1; inst = 1; sni = 0; bpen = 1; bpa = 12'h5a5; cur = 12'h5a5;
    repeat (11) cycle();
    check("R4 reach pulse 12", {28'd0, st}, 32'd12);
    check("R9 pulse 12 bit", {20'd0, tp}, 32'h800);
    cycle();
    check("R5 loop", {28'd0, st}, 32'd1);
    check("R10 hit", {31'd0, fm}, 32'd1);
    cycle();
    check("R10 one cycle", {31'd0, fm}, 32'd0);
    // mismatch: no flag
    cur = 12'h5a4;
    repeat (11) cycle();
    cycle();
    check("R10 mismatch", {31'd0, fm}, 32'd0);
    // stop via select-next-instruction
    cur = 12'h5a5; bpen = 0; sni = 1; step = 1;
    repeat (11) cycle();
    cycle();
    check("R5 stop", {28'd0, st}, 32'd14);
    check("R10 disabled", {31'd0, fm}, 32'd0);
    check("R9 idle zero", {20'd0, tp}, 32'd0);
    fast = 0;
    repeat (4) cycle();
    check("R7 held button", {28'd0, st}, 32'd14);
    step = 0;
    repeat (4) cycle();
    check("R7 released", {28'd0, st}, 32'd15);
    step = 1;
    repeat (4) cycle();
    check("R8 one move", {28'd0, st}, 32'd1);
    repeat (6) cycle();
    check("R8 held no repeat", {28'd0, st}, 32'd1);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      fast = ($urandom % 3) == 0;
      slow = ($urandom % 12) == 0;
      if (($urandom % 30) == 0) por = ~por;
      if (($urandom % 15) == 0) step = ~step;
      run  = ($urandom % 4) != 0;
      inst = ($urandom % 4) != 0;
      sni  = ($urandom % 6) == 0;
      bpen = $urandom % 2;
      bpa  = 12'h123;
      cur  = (($urandom % 3) == 0) ? 12'h123 : 12'($urandom);
      if (($urandom % 1500) == 0) do_reset();
      else cycle();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule